// File: doc/BRIEF.md
# Fault Report Peripheral

This block tells a processor that a fault has been detected, the way parity-checked hardware does when a damaged location is touched. An injection or detection source outside the block posts single events. Each event is either a register fault, carrying the identifier of the affected processor register, or a memory fault, carrying the accessed address and the width of the access. On a posted event the block latches the details into three readable registers and raises an interrupt request.

Memory faults are never reported at an exact bit or byte. The address is rounded down to a word boundary and a size in bytes is reported with it, so software learns only that one or more bits somewhere inside that range are bad. The meaning of the second and third registers depends on the recorded fault type.

Software reads the registers over a simple single-cycle register bus and acknowledges by writing to the type register. The block holds one fault at a time. An event that arrives while an earlier fault is still unacknowledged is discarded, and a sticky flag records the loss.

Top module: `fault_report_unit`

## Requirements
- R1: After synchronous reset the interrupt line is low and every register reads zero.
- R2: An event posted while no fault is held is latched and raises `irq` from the next clock edge onward; `irq` stays high until acknowledged.
- R3: Registers sit at byte offsets 0x0 (type), 0x4 (info A) and 0x8 (info B). Type bits [1:0] encode 0 = none, 1 = register fault, 2 = memory fault, and bit 31 is the overflow flag. Any other offset, and any cycle without a read, returns zero on `bus_rdata`.
- R4: For a register fault, info A holds the register identifier zero-extended and info B reads zero.
- R5: For a memory fault, info A holds the event address with bits [1:0] cleared.
- R6: For a memory fault, info B holds the range size in bytes from the width code (0 = byte, 1 = halfword, 2 = word, 3 = doubleword): four for codes 0 to 2 and eight for code 3.
- R7: A write of any value to offset 0x0 clears type, overflow, info A, info B and `irq` at the next edge; writes to 0x4 and 0x8 change nothing.
- R8: An event that arrives while a fault is held, with no acknowledge in the same cycle, is dropped: info A, info B and type stay unchanged and bit 31 of the type register becomes 1.
- R9: An acknowledge and an event in the same cycle release the old fault and latch the new one: the overflow flag clears, the new details are readable and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Posts one fault event this cycle |
| evt_is_mem | input | 1 | 1 = memory fault, 0 = register fault |
| evt_reg_id | input | REGID_W | Identifier of the affected register |
| evt_addr | input | ADDR_W | Address of the faulty memory access |
| evt_width | input | 2 | Access width code of the memory access |
| bus_sel | input | 1 | Register bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFF_W | Byte offset into the register block |
| bus_wdata | input | 32 | Write data (value ignored) |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | 1 | Interrupt request, high while a fault is held |

## Verification
The acknowledge write and a newly posted event can land on the same clock edge, which is where the drop policy and the release policy meet. The bench drives both in one cycle while a fault is held and checks that the new details appear, the overflow flag is gone and the interrupt never falls. A behavioural model in the bench, updated at every edge with the held fault, the overflow flag and the interrupt, is compared against `irq` and `bus_rdata` in every cycle, so a wrong priority between the two shows up at once.

// File: rtl/fru_pkg.sv
package fru_pkg;

    localparam int unsigned WORD_BYTES = 4;

    localparam logic [3:0] OFS_KIND  = 4'h0;
    localparam logic [3:0] OFS_INFOA = 4'h4;
    localparam logic [3:0] OFS_INFOB = 4'h8;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_REG  = 2'd1,
        KIND_MEM  = 2'd2
    } fault_kind_e;

    typedef struct packed {
        fault_kind_e kind;
        logic [31:0] info_a;
        logic [31:0] info_b;
    } fault_rec_t;

    // Reported range size: never below one word.
    function automatic logic [31:0] range_bytes(input logic [1:0] width_code);
        logic [31:0] raw;
        raw = 32'd1 << width_code;
        return (raw < WORD_BYTES) ? 32'(WORD_BYTES) : raw;
    endfunction

    function automatic logic [31:0] word_floor(input logic [31:0] a);
        return a & ~32'(WORD_BYTES - 1);
    endfunction

endpackage

// File: rtl/fru_format.sv
module fru_format
    import fru_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned REGID_W = 5
) (
    input  logic               is_mem,
    input  logic [REGID_W-1:0] reg_id,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         width,
    output fault_rec_t         rec
);
    always_comb begin
        if (is_mem) begin
            rec.kind   = KIND_MEM;
            rec.info_a = word_floor(32'(addr));
            rec.info_b = range_bytes(width);
        end else begin
            rec.kind   = KIND_REG;
            rec.info_a = 32'(reg_id);
            rec.info_b = '0;
        end
    end
endmodule

// File: rtl/fru_hold.sv
module fru_hold
    import fru_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       post,
    input  fault_rec_t new_rec,
    input  logic       ack,
    output fault_rec_t held,
    output logic       ovf,
    output logic       pending
);
    assign pending = (held.kind != KIND_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            ovf  <= 1'b0;
        end else begin
            if (ack) begin
                held <= '0;
                ovf  <= 1'b0;
            end
            if (post) begin
                if (pending && !ack) ovf  <= 1'b1;
                else                 held <= new_rec;
            end
        end
    end

    p_capture_raises_r2: assert property (@(posedge clk) disable iff (rst)
        (post && !pending) |=> pending);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && !post) |=> (!pending && !ovf && held.info_a == 32'd0));

    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (post && pending && !ack) |=> ($stable(held) && ovf));

    p_both_same_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (post && ack) |=> (pending && !ovf));

    p_mem_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (held.kind == KIND_MEM) |-> (held.info_a[1:0] == 2'b00));

    p_reg_infob_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (held.kind == KIND_REG) |-> (held.info_b == 32'd0));
endmodule

// File: rtl/fru_readmux.sv
module fru_readmux
    import fru_pkg::*;
#(
    parameter int unsigned OFF_W = 4
) (
    input  logic             rd_en,
    input  logic [OFF_W-1:0] off,
    input  fault_rec_t       held,
    input  logic             ovf,
    output logic [31:0]      rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (off)
                OFF_W'(OFS_KIND):  rdata = {ovf, 29'd0, held.kind};
                OFF_W'(OFS_INFOA): rdata = held.info_a;
                OFF_W'(OFS_INFOB): rdata = held.info_b;
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fault_report_unit.sv
module fault_report_unit
    import fru_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned REGID_W = 5,
    parameter int unsigned OFF_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic               evt_is_mem,
    input  logic [REGID_W-1:0] evt_reg_id,
    input  logic [ADDR_W-1:0]  evt_addr,
    input  logic [1:0]         evt_width,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [OFF_W-1:0]   bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq
);
    fault_rec_t new_rec;
    fault_rec_t held;
    logic       ovf;
    logic       pending;
    logic       ack;
    logic       rd_en;
    logic       unused_wdata;

    assign ack          = bus_sel && bus_wr && (bus_addr == OFF_W'(OFS_KIND));
    assign rd_en        = bus_sel && !bus_wr;
    assign unused_wdata = ^bus_wdata;

    fru_format #(.ADDR_W(ADDR_W), .REGID_W(REGID_W)) u_format (
        .is_mem (evt_is_mem),
        .reg_id (evt_reg_id),
        .addr   (evt_addr),
        .width  (evt_width),
        .rec    (new_rec)
    );

    fru_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .post    (evt_valid),
        .new_rec (new_rec),
        .ack     (ack),
        .held    (held),
        .ovf     (ovf),
        .pending (pending)
    );

    fru_readmux #(.OFF_W(OFF_W)) u_readmux (
        .rd_en (rd_en),
        .off   (bus_addr),
        .held  (held),
        .ovf   (ovf),
        .rdata (bus_rdata)
    );

    assign irq = pending;

    p_irq_low_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !irq);
endmodule

// File: tb/test_fault_report_unit.sv
module test_fault_report_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 0, evt_is_mem = 0;
    logic [4:0]  evt_reg_id = 0;
    logic [31:0] evt_addr = 0;
    logic [1:0]  evt_width = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int unsigned m_kind = 0;
    bit          m_ovf  = 0;
    logic [31:0] m_a = 0, m_b = 0;

    always #2 clk = ~clk;

    fault_report_unit i_fault_report_unit (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_is_mem(evt_is_mem), .evt_reg_id(evt_reg_id),
        .evt_addr(evt_addr), .evt_width(evt_width),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rdata();
        if (!bus_sel || bus_wr) return 32'd0;
        case (bus_addr)
            4'h0: return (32'(m_ovf) << 31) | 32'(m_kind);
            4'h4: return m_a;
            4'h8: return m_b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_size(input logic [1:0] w);
        case (w)
            2'd3:    return 32'd8;
            default: return 32'd4;
        endcase
    endfunction

    // one cycle: compare now, then advance the model at the edge
    task automatic step(input string tag);
        logic [31:0] e;
        bit ack, busy;
        #1;
        e = exp_rdata();
        n_checks++;
        if (irq !== (m_kind != 0)) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, (m_kind != 0));
        end
        n_checks++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s rdata@%h actual=%h expected=%h", tag, bus_addr, bus_rdata, e);
        end
        @(posedge clk);
        ack  = bus_sel && bus_wr && (bus_addr == 4'h0);
        busy = (m_kind != 0) && !ack;
        if (ack) begin m_kind = 0; m_ovf = 0; m_a = 0; m_b = 0; end
        if (evt_valid) begin
            if (busy) m_ovf = 1;
            else if (evt_is_mem) begin
                m_kind = 2; m_a = {evt_addr[31:2], 2'b00}; m_b = exp_size(evt_width);
            end else begin
                m_kind = 1; m_a = {27'd0, evt_reg_id}; m_b = 0;
            end
        end
        @(negedge clk);
        evt_valid = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] off, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = off; step(tag);
    endtask
    task automatic wr(input logic [3:0] off, input logic [31:0] d, input string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = off; bus_wdata = d; step(tag);
    endtask
    task automatic set_reg(input logic [4:0] id);
        evt_valid = 1; evt_is_mem = 0; evt_reg_id = id;
    endtask
    task automatic set_mem(input logic [31:0] a, input logic [1:0] w);
        evt_valid = 1; evt_is_mem = 1; evt_addr = a; evt_width = w;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
        // R2 / R4 register fault capture
        set_reg(5'd13); step("R2");
        rd(4'h0, "R3"); rd(4'h4, "R4"); rd(4'h8, "R4");
        // R8 drop while pending
        set_mem(32'h0000_ABCD, 2'd2); step("R8");
        rd(4'h0, "R8"); rd(4'h4, "R8"); rd(4'h8, "R8");
        // R7 writes to info registers ignored
        wr(4'h4, 32'hFFFF_FFFF, "R7"); wr(4'h8, 32'h1234_5678, "R7");
        rd(4'h4, "R7"); rd(4'h0, "R7");
        // R7 acknowledge
        wr(4'h0, 32'h0, "R7");
        rd(4'h0, "R7"); rd(4'h4, "R7"); rd(4'h8, "R7");
        // R5 / R6 byte access, unaligned
        set_mem(32'h0000_1003, 2'd0); step("R5");
        rd(4'h0, "R3"); rd(4'h4, "R5"); rd(4'h8, "R6");
        // R9 acknowledge and event together, with overflow set first
        set_reg(5'd2); step("R8");
        rd(4'h0, "R8");
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'hDEAD_BEEF;
        set_mem(32'h0000_2006, 2'd1); step("R9");
        rd(4'h0, "R9"); rd(4'h4, "R9"); rd(4'h8, "R9");
        // R6 word and doubleword sizes
        wr(4'h0, 32'h1, "R7");
        set_mem(32'h0000_0032, 2'd2); step("R6");
        rd(4'h8, "R6"); rd(4'h4, "R5");
        wr(4'h0, 32'h0, "R7");
        set_mem(32'hFFFF_FFFF, 2'd3); step("R6");
        rd(4'h8, "R6"); rd(4'h4, "R5");
        // R4 info B reads zero after memory fault history
        wr(4'h0, 32'h0, "R7");
        set_reg(5'd31); step("R4");
        rd(4'h4, "R4"); rd(4'h8, "R4");
        // R3 unmapped offset and write cycles read zero
        rd(4'hC, "R3"); rd(4'h2, "R3");
        wr(4'h0, 32'h0, "R7");
        rd(4'h0, "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule